// File: doc/BRIEF.md
# Latched interlock decision cell

This block makes the interlock decision for one power-supply regulator station. It receives nineteen digitised interlock bits, each 1 when its condition is healthy and 0 when it demands a trip. The bits are: seven module temperatures, one over-temperature flag, one optical-transceiver temperature, seven station temperatures, one safety-system signal, one laser-enclosure signal and one cable-patch signal. From these it drives three fail-safe enables: high voltage, low voltage (analog and digital supplies together), and optical-link supply.

Each input passes through a two-flop synchroniser into a trip latch. The latch holds a trip after the input recovers, until a clear command arrives while the input is healthy. A transparent debug mode turns latching off, so that each latch follows its live input. Each module temperature can be switched off on its own, and the seven station temperatures share one disable switch. A switched-off channel can never trip. It is reported with its own status code, so a technician can tell an unplugged channel from a real trip.

Top module: `ilk_matrix_cell`

## Requirements
- R1: Channel index order, used by the status vector, is: module temperatures 0..6, over-temperature flag 7, optical-transceiver temperature 8, station temperatures 9..15, safety system 16, laser enclosure 17, cable patch 18. Channel k's status sits in chan_status_o[2k+1:2k].
- R2: The status codes are 2'b00 healthy, 2'b01 tripped and 2'b10 switched off. A switched-off channel reads 2'b10 whatever its input, and 2'b11 never appears.
- R3: With transparent mode off and no clear, a channel whose synchronised input is 0 stays tripped after its input returns to 1.
- R4: A clear pulse removes the trip only from channels whose synchronised input is 1 at that clock edge. A channel still at 0 stays tripped.
- R5: With transparent_i high, each enabled channel's trip follows its synchronised input, and recovery needs no clear.
- R6: hv_ok_o is 0 when any enabled channel is tripped.
- R7: lv_ok_o is 0 when any enabled temperature channel (indices 0..15) or the safety-system channel is tripped. The laser and patch channels do not affect it.
- R8: link_ok_o is 0 when the optical-transceiver temperature, laser-enclosure or cable-patch channel is tripped. No other channel affects it.
- R9: Setting mod_disable_i[i] switches off module temperature channel i alone.
- R10: stn_disable_i switches off all seven station temperature channels together.
- R11: A switched-off channel's latch is held clear, so re-enabling it shows no stale trip.
- R12: An input change driven between clock edges shows on the outputs and status at the fourth following rising edge: two synchroniser stages, the latch, then the output register.
- R13: While rst_n is low, all three outputs are 0 and every status field is 2'b00. Latches start clear, and with healthy inputs the outputs read 1 within two edges of release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_temp_ok_i | input | 7 | Module temperature interlocks, 1 = healthy |
| hot_flag_ok_i | input | 1 | Over-temperature flag, 1 = healthy |
| opto_temp_ok_i | input | 1 | Optical-transceiver temperature, 1 = healthy |
| stn_temp_ok_i | input | 7 | Station temperature interlocks, 1 = healthy |
| safety_ok_i | input | 1 | Safety-system signal, 1 = healthy |
| laser_ok_i | input | 1 | Laser-enclosure signal, 1 = healthy |
| panel_ok_i | input | 1 | Cable-patch signal, 1 = healthy |
| mod_disable_i | input | 7 | Per-module switch-off, 1 = off |
| stn_disable_i | input | 1 | Switch-off for all station temperatures |
| transparent_i | input | 1 | Debug mode with no latching |
| clear_i | input | 1 | Synchronous trip clear command |
| hv_ok_o | output | 1 | High-voltage enable, 1 = allowed |
| lv_ok_o | output | 1 | Low-voltage enable, 1 = allowed |
| link_ok_o | output | 1 | Optical-link supply enable, 1 = allowed |
| chan_status_o | output | 38 | Two-bit status per channel |

## Verification
A clear command can reach the latch in the same cycle as a channel whose synchronised input is still low. That clear must leave the channel tripped, while other channels that have recovered are released. The bench provokes this by holding one input low through a clear pulse. It also holds one of two tripped channels low while the other has already recovered. It then judges the individual status fields and the affected output a cycle after the pulse.

// File: rtl/ilk_cell_pkg.sv
package ilk_cell_pkg;

    typedef enum logic [1:0] {
        ST_HEALTHY = 2'b00,
        ST_TRIPPED = 2'b01,
        ST_OFF     = 2'b10
    } chan_state_e;

endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
    parameter int unsigned    W       = 19,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = async_i;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{stage1: RST_VAL, stage2: RST_VAL};
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stage2;

endmodule

// File: rtl/ilk_trip_bank.sv
module ilk_trip_bank #(
    parameter int unsigned W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ok_sync_i,
    input  logic [W-1:0] enable_i,
    input  logic         clear_i,
    input  logic         transparent_i,
    output logic [W-1:0] trip_o
);

    logic [W-1:0] trip_d, trip_q;

    // One latch per channel: a low input sets it; it holds unless a clear
    // or transparent mode lets a healthy input release it.
    for (genvar k = 0; k < W; k++) begin : g_chan
        logic hold;
        always_comb begin
            hold      = trip_q[k] & ~clear_i & ~transparent_i;
            trip_d[k] = enable_i[k] & (~ok_sync_i[k] | hold);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q <= '0;
        end else begin
            trip_q <= trip_d;
        end
    end

    assign trip_o = trip_q;

endmodule

// File: rtl/ilk_out_stage.sv
module ilk_out_stage
    import ilk_cell_pkg::*;
#(
    parameter int unsigned W = 19
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   trip_i,
    input  logic [W-1:0]   enable_i,
    input  logic [W-1:0]   lv_group_i,
    input  logic [W-1:0]   link_group_i,
    output logic           hv_ok_o,
    output logic           lv_ok_o,
    output logic           link_ok_o,
    output logic [2*W-1:0] status_o
);

    typedef struct packed {
        logic           hv;
        logic           lv;
        logic           link;
        logic [2*W-1:0] status;
    } out_t;

    out_t o_d, o_q;
    logic [W-1:0] live_trip;

    always_comb begin
        o_d       = o_q;
        live_trip = trip_i & enable_i;
        o_d.hv    = ~|live_trip;
        o_d.lv    = ~|(live_trip & lv_group_i);
        o_d.link  = ~|(live_trip & link_group_i);
        for (int k = 0; k < W; k++) begin
            if (!enable_i[k]) begin
                o_d.status[2*k +: 2] = ST_OFF;
            end else if (trip_i[k]) begin
                o_d.status[2*k +: 2] = ST_TRIPPED;
            end else begin
                o_d.status[2*k +: 2] = ST_HEALTHY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{hv: 1'b0, lv: 1'b0, link: 1'b0, status: '0};
        end else begin
            o_q <= o_d;
        end
    end

    assign hv_ok_o   = o_q.hv;
    assign lv_ok_o   = o_q.lv;
    assign link_ok_o = o_q.link;
    assign status_o  = o_q.status;

endmodule

// File: rtl/ilk_matrix_cell.sv
module ilk_matrix_cell #(
    parameter int unsigned N_MOD = 7,
    parameter int unsigned N_STN = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_MOD-1:0]                  mod_temp_ok_i,
    input  logic                              hot_flag_ok_i,
    input  logic                              opto_temp_ok_i,
    input  logic [N_STN-1:0]                  stn_temp_ok_i,
    input  logic                              safety_ok_i,
    input  logic                              laser_ok_i,
    input  logic                              panel_ok_i,
    input  logic [N_MOD-1:0]                  mod_disable_i,
    input  logic                              stn_disable_i,
    input  logic                              transparent_i,
    input  logic                              clear_i,
    output logic                              hv_ok_o,
    output logic                              lv_ok_o,
    output logic                              link_ok_o,
    output logic [2*(N_MOD+N_STN+5)-1:0]      chan_status_o
);

    localparam int unsigned IDX_HOT   = N_MOD;
    localparam int unsigned IDX_OPTO  = N_MOD + 1;
    localparam int unsigned IDX_STN   = N_MOD + 2;
    localparam int unsigned IDX_SAFE  = IDX_STN + N_STN;
    localparam int unsigned IDX_LASER = IDX_SAFE + 1;
    localparam int unsigned IDX_PANEL = IDX_SAFE + 2;
    localparam int unsigned N_CH      = IDX_SAFE + 3;

    function automatic logic [N_CH-1:0] lv_members();
        logic [N_CH-1:0] m;
        m = '0;
        for (int k = 0; k <= int'(IDX_SAFE); k++) m[k] = 1'b1;
        return m;
    endfunction

    function automatic logic [N_CH-1:0] link_members();
        logic [N_CH-1:0] m;
        m = '0;
        m[IDX_OPTO]  = 1'b1;
        m[IDX_LASER] = 1'b1;
        m[IDX_PANEL] = 1'b1;
        return m;
    endfunction

    localparam logic [N_CH-1:0] LV_GRP   = lv_members();
    localparam logic [N_CH-1:0] LINK_GRP = link_members();

    logic [N_CH-1:0] ok_raw;
    logic [N_CH-1:0] ok_sync;
    logic [N_CH-1:0] chan_en;
    logic [N_CH-1:0] trip_q;

    assign ok_raw  = {panel_ok_i, laser_ok_i, safety_ok_i, stn_temp_ok_i,
                      opto_temp_ok_i, hot_flag_ok_i, mod_temp_ok_i};
    assign chan_en = {3'b111, {N_STN{~stn_disable_i}}, 2'b11, ~mod_disable_i};

    ilk_sync #(
        .W       (N_CH),
        .RST_VAL ({N_CH{1'b1}})
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ok_raw),
        .sync_o  (ok_sync)
    );

    ilk_trip_bank #(
        .W (N_CH)
    ) i_trip (
        .clk           (clk),
        .rst_n         (rst_n),
        .ok_sync_i     (ok_sync),
        .enable_i      (chan_en),
        .clear_i       (clear_i),
        .transparent_i (transparent_i),
        .trip_o        (trip_q)
    );

    ilk_out_stage #(
        .W (N_CH)
    ) i_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .trip_i       (trip_q),
        .enable_i     (chan_en),
        .lv_group_i   (LV_GRP),
        .link_group_i (LINK_GRP),
        .hv_ok_o      (hv_ok_o),
        .lv_ok_o      (lv_ok_o),
        .link_ok_o    (link_ok_o),
        .status_o     (chan_status_o)
    );

endmodule

module ilk_matrix_cell_chk #(
    parameter int unsigned W        = 19,
    parameter int unsigned IDX_SAFE = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clear_i,
    input logic           transparent_i,
    input logic [W-1:0]   ok_sync,
    input logic [W-1:0]   chan_en,
    input logic [W-1:0]   trip_q,
    input logic           hv_ok_o,
    input logic           lv_ok_o,
    input logic           link_ok_o,
    input logic [2*W-1:0] chan_status_o
);

    // R2
    always @(posedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < int'(W); k++) begin
                status_code_chk: assert (chan_status_o[2*k +: 2] != 2'b11)
                    else $error("status code 11 on channel %0d", k);
            end
        end
    end

    // R3
    sticky_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !transparent_i && $stable(chan_en))
        |=> ((trip_q & $past(trip_q)) == $past(trip_q)));

    // R4
    low_input_keeps_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((~$past(ok_sync) & $past(chan_en) & ~trip_q) == '0));

    // R11
    off_channel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((trip_q & ~$past(chan_en)) == '0));

    // R7
    safety_drops_lv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_q[IDX_SAFE]) |=> (!lv_ok_o && !hv_ok_o));

    // R6
    hv_covers_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hv_ok_o |-> (lv_ok_o && link_ok_o));

endmodule

bind ilk_matrix_cell ilk_matrix_cell_chk #(
    .W        (N_CH),
    .IDX_SAFE (IDX_SAFE)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear_i),
    .transparent_i (transparent_i),
    .ok_sync       (ok_sync),
    .chan_en       (chan_en),
    .trip_q        (trip_q),
    .hv_ok_o       (hv_ok_o),
    .lv_ok_o       (lv_ok_o),
    .link_ok_o     (link_ok_o),
    .chan_status_o (chan_status_o)
);

// File: tb/test_ilk_matrix_cell.sv
module test_ilk_matrix_cell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  mod_ok = '1;
    logic        hot_ok = 1'b1, opto_ok = 1'b1;
    logic [6:0]  stn_ok = '1;
    logic        safe_ok = 1'b1, laser_ok = 1'b1, panel_ok = 1'b1;
    logic [6:0]  mod_dis = '0;
    logic        stn_dis = 1'b0, transp = 1'b0, clear = 1'b0;
    logic        hv, lv, link;
    logic [37:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ilk_matrix_cell i_ilk_matrix_cell (
        .clk            (clk),
        .rst_n          (rst_n),
        .mod_temp_ok_i  (mod_ok),
        .hot_flag_ok_i  (hot_ok),
        .opto_temp_ok_i (opto_ok),
        .stn_temp_ok_i  (stn_ok),
        .safety_ok_i    (safe_ok),
        .laser_ok_i     (laser_ok),
        .panel_ok_i     (panel_ok),
        .mod_disable_i  (mod_dis),
        .stn_disable_i  (stn_dis),
        .transparent_i  (transp),
        .clear_i        (clear),
        .hv_ok_o        (hv),
        .lv_ok_o        (lv),
        .link_ok_o      (link),
        .chan_status_o  (status)
    );

    // ok bits: [6:0] module, 7 hot, 8 opto, [15:9] station, 16 safety, 17 laser, 18 patch
    typedef struct packed {
        logic [18:0] ok;
        logic [6:0]  mdis;
        logic        sdis;
        logic [2:0]  exp_out;   // {hv, lv, link}
    } vec_t;

    localparam vec_t VECS [0:10] = '{
        '{19'h7FFFF, 7'h00, 1'b0, 3'b111},
        '{19'h7FFF7, 7'h00, 1'b0, 3'b001},
        '{19'h7FFBF, 7'h40, 1'b0, 3'b111},
        '{19'h7EFFF, 7'h00, 1'b1, 3'b111},
        '{19'h7EFFF, 7'h00, 1'b0, 3'b001},
        '{19'h5FFFF, 7'h00, 1'b0, 3'b010},
        '{19'h3FFFF, 7'h00, 1'b0, 3'b010},
        '{19'h6FFFF, 7'h00, 1'b0, 3'b001},
        '{19'h7FEFF, 7'h00, 1'b0, 3'b000},
        '{19'h7FF7F, 7'h00, 1'b0, 3'b001},
        '{19'h00000, 7'h7F, 1'b1, 3'b000}
    };

    function automatic logic [37:0] exp_status(logic [18:0] ok, logic [6:0] mdis, logic sdis);
        logic [37:0] s;
        s = '0;
        for (int k = 0; k < 19; k++) begin
            logic off;
            off = (k < 7) ? mdis[k] : ((k >= 9 && k <= 15) ? sdis : 1'b0);
            if (off)        s[2*k +: 2] = 2'b10;
            else if (!ok[k]) s[2*k +: 2] = 2'b01;
        end
        return s;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [18:0] ok);
        mod_ok   = ok[6:0];
        hot_ok   = ok[7];
        opto_ok  = ok[8];
        stn_ok   = ok[15:9];
        safe_ok  = ok[16];
        laser_ok = ok[17];
        panel_ok = ok[18];
    endtask

    task automatic pulse_clear();
        clear = 1'b1;
        tick(1);
        clear = 1'b0;
    endtask

    task automatic restore();
        drive('1);
        mod_dis = '0;
        stn_dis = 1'b0;
        transp  = 1'b0;
        tick(4);
        pulse_clear();
        tick(3);
    endtask

    initial begin
        tick(3);
        // R13: reset state
        check("R13 outputs in reset", {hv, lv, link}, 3'b000);
        check("R13 status in reset", status, '0);
        rst_n = 1'b1;
        tick(2);
        check("R13 outputs after release", {hv, lv, link}, 3'b111);

        // R1 R2 R6 R7 R8 R9 R10: table walk
        foreach (VECS[i]) begin
            drive(VECS[i].ok);
            mod_dis = VECS[i].mdis;
            stn_dis = VECS[i].sdis;
            tick(6);
            check($sformatf("R6 R7 R8 R9 R10 vector %0d outputs", i), {hv, lv, link}, VECS[i].exp_out);
            check($sformatf("R1 R2 vector %0d status", i), status,
                  exp_status(VECS[i].ok, VECS[i].mdis, VECS[i].sdis));
            restore();
        end
        check("R3 clean after table", {hv, lv, link}, 3'b111);

        // R12: latency of four rising edges
        safe_ok = 1'b0;
        tick(3);
        check("R12 lv before fourth edge", lv, 1'b1);
        tick(1);
        check("R12 R7 outputs at fourth edge", {hv, lv, link}, 3'b001);
        check("R12 safety status", status[33:32], 2'b01);

        // R3: trip held after recovery
        safe_ok = 1'b1;
        tick(6);
        check("R3 lv held", lv, 1'b0);
        check("R3 status held", status[33:32], 2'b01);

        // R4: clear while input still low
        safe_ok = 1'b0;
        tick(4);
        pulse_clear();
        tick(4);
        check("R4 clear blocked by low input", lv, 1'b0);
        safe_ok = 1'b1;
        tick(4);
        pulse_clear();
        tick(1);
        check("R4 clear releases healthy input", {hv, lv, link}, 3'b111);

        // R4: clear in the same cycle as one low and one recovered channel
        laser_ok = 1'b0;
        panel_ok = 1'b0;
        tick(5);
        laser_ok = 1'b1;
        tick(4);
        pulse_clear();
        tick(1);
        check("R4 recovered laser released", status[35:34], 2'b00);
        check("R4 low patch kept", status[37:36], 2'b01);
        check("R8 link still down", link, 1'b0);
        check("R7 lv unaffected by patch", lv, 1'b1);
        panel_ok = 1'b1;
        tick(4);
        pulse_clear();
        tick(1);
        check("R8 link back", link, 1'b1);

        // R5: transparent mode
        transp = 1'b1;
        mod_ok[0] = 1'b0;
        tick(5);
        check("R5 trip follows input", hv, 1'b0);
        mod_ok[0] = 1'b1;
        tick(5);
        check("R5 recovery without clear", hv, 1'b1);
        check("R5 status healthy", status[1:0], 2'b00);
        transp = 1'b0;
        tick(2);

        // R9 R11: switching off a latched channel
        mod_ok[2] = 1'b0;
        tick(5);
        mod_ok[2] = 1'b1;
        tick(4);
        check("R3 module trip held", hv, 1'b0);
        mod_dis[2] = 1'b1;
        tick(2);
        check("R9 status off", status[5:4], 2'b10);
        check("R9 hv restored", hv, 1'b1);
        mod_dis[2] = 1'b0;
        tick(2);
        check("R11 no stale trip", status[5:4], 2'b00);
        check("R11 hv stays", hv, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule